// File: doc/BRIEF.md
# CAN wake frame ID matcher

This block decides whether one CAN frame, already decoded by a receiver upstream, qualifies as a wake-up frame. The receiver presents the frame's identifier, IDE and RTR bits, DLC and up to eight payload bytes, together with a one-cycle frame-valid strobe. The block compares them against a programmed wake filter. When the frame qualifies and the external wake enable is high, the block emits a one-cycle match pulse.

The filter is loaded through a byte-wide write port. It holds the following:

- A reference identifier with its IDE selection. The identifier is packed across four bytes.
- An identifier mask with the same packing. A mask bit of 1 makes that identifier bit a don't-care.
- A control byte carrying a reference DLC and a data-test enable.
- Eight payload pattern bytes.

With the data test off, the identifier alone decides and remote frames may wake. With it on, the DLC must match and remote frames are refused. The payload must also share at least one set bit with the pattern within the bytes the frame actually carries.

Top module: `wake_frame_matcher`

## Requirements
- R1: While reset is active and afterwards until the first qualifying frame, `wake_match` is 0. Every filter field resets to 0, so after reset a standard frame with identifier 0 matches and one with any other standard identifier does not.
- R2: `wake_match` is 1 in exactly the clock cycle after the cycle in which `frm_valid` is sampled high with a qualifying frame, and is 1 for that single cycle only.
- R3: For each identifier bit taking part in the comparison, a mask bit of 1 makes that bit a don't-care, and a mask bit of 0 requires the frame bit to equal the reference bit.
- R4: A frame whose IDE bit differs from the programmed IDE bit never matches. IDE 0 means an 11-bit standard identifier and IDE 1 means a 29-bit extended identifier.
- R5: The reference identifier `id[28:0]` is written byte-wise.
  - Address 0 holds `id[17:10]`.
  - Address 1 holds `id[9:2]`.
  - Address 2 holds `{id[1:0], ide, id[28:24]}`, with `id[1:0]` in bits 7:6, `ide` in bit 5 and `id[28:24]` in bits 4:0.
  - Address 3 holds `id[23:18]` in bits 7:2. Its bits 1:0 are ignored.
  - Addresses 4 to 7 hold the mask with the same layout. Bit 5 of address 6 is ignored.
- R6: A standard identifier sits in `frm_id[28:18]` and in reference and mask bits 28:18. For standard frames, bits 17:0 are not compared.
- R7: With data-test enable 0, the frame's RTR bit, DLC and payload have no effect on the result.
- R8: With data-test enable 1, a frame matches only if its DLC equals the programmed 4-bit DLC and its RTR bit is 0.
- R9: With data-test enable 1, the data test passes when some payload bit and the same pattern bit are both 1. Byte equality is not required.
- R10: Only the first min(DLC, 8) payload bytes take part in the data test. Byte k is `frm_data[8k+7:8k]`. A frame with DLC 0 fails the data test.
- R11: When `wake_en` is 0 in the strobe cycle, no match pulse follows.
- R12: Address 8 carries the reference DLC in bits 3:0 and the data-test enable in bit 4. Addresses 9 to 16 carry pattern bytes 0 to 7. Writes to addresses above 16 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Filter byte write strobe |
| cfg_addr | input | 5 | Filter byte address |
| cfg_wdata | input | 8 | Filter byte write data |
| wake_en | input | 1 | External wake enable |
| frm_valid | input | 1 | One-cycle strobe: decoded frame fields are valid |
| frm_id | input | 29 | Frame identifier (standard ID in bits 28:18) |
| frm_ide | input | 1 | Frame IDE bit |
| frm_rtr | input | 1 | Frame RTR bit (1 = remote frame) |
| frm_dlc | input | 4 | Frame data length code |
| frm_data | input | 64 | Payload, byte k in bits 8k+7:8k |
| wake_match | output | 1 | One-cycle wake-match pulse |

## Verification
The only state in the block is the filter fields and the pulse flop. A wrong internal state therefore shows up at the port one cycle after the next strobe, as a missing pulse or a pulse that should not be there. A byte written into the wrong field stays hidden until a frame tests that exact field. For this reason, the frames are chosen so that each identifier byte, mask byte, control bit and pattern byte flips the outcome by itself. Pulse timing and width are checked one cycle after the strobe and again on the cycle that follows it.

// File: rtl/wkm_pkg.sv
package wkm_pkg;
  localparam int ID_W      = 29;
  localparam int STD_W     = 11;
  localparam int DLC_W     = 4;
  localparam int MAX_BYTES = 8;
  localparam int BYTE_W    = 8;
  localparam int PAY_W     = MAX_BYTES * BYTE_W;
  localparam int NUM_REGS  = 9 + MAX_BYTES;
  localparam int ADDR_W    = $clog2(NUM_REGS);

  localparam logic [ADDR_W-1:0] A_ID0   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_ID1   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_ID2   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_ID3   = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_MSK0  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_MSK1  = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_MSK2  = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_MSK3  = ADDR_W'(7);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(8);
  localparam int                A_PAT0  = 9;

  typedef struct packed {
    logic [ID_W-1:0]  id;
    logic             ide;
    logic [ID_W-1:0]  mask;
    logic [DLC_W-1:0] dlc;
    logic             dme;
    logic [PAY_W-1:0] pat;
  } wkm_cfg_t;
endpackage

// File: rtl/wkm_cfg_regs.sv
module wkm_cfg_regs
  import wkm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output wkm_cfg_t          cfg
);
  wkm_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (we) begin
      case (addr)
        A_ID0:  cfg_d.id[17:10] = wdata;
        A_ID1:  cfg_d.id[9:2]   = wdata;
        A_ID2: begin
          cfg_d.id[1:0]   = wdata[7:6];
          cfg_d.ide       = wdata[5];
          cfg_d.id[28:24] = wdata[4:0];
        end
        A_ID3:  cfg_d.id[23:18]   = wdata[7:2];
        A_MSK0: cfg_d.mask[17:10] = wdata;
        A_MSK1: cfg_d.mask[9:2]   = wdata;
        A_MSK2: begin
          cfg_d.mask[1:0]   = wdata[7:6];
          cfg_d.mask[28:24] = wdata[4:0];
        end
        A_MSK3: cfg_d.mask[23:18] = wdata[7:2];
        A_CTRL: begin
          cfg_d.dme = wdata[4];
          cfg_d.dlc = wdata[3:0];
        end
        default: begin
          for (int k = 0; k < MAX_BYTES; k++) begin
            if (addr == ADDR_W'(A_PAT0 + k)) cfg_d.pat[k*BYTE_W +: BYTE_W] = wdata;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/wkm_id_cmp.sv
module wkm_id_cmp
  import wkm_pkg::*;
(
  input  logic [ID_W-1:0] ref_id,
  input  logic [ID_W-1:0] ref_mask,
  input  logic            ref_ide,
  input  logic [ID_W-1:0] frm_id,
  input  logic            frm_ide,
  output logic            id_hit
);
  localparam logic [ID_W-1:0] STD_WIN = {{STD_W{1'b1}}, {(ID_W-STD_W){1'b0}}};

  logic [ID_W-1:0] care;
  logic [ID_W-1:0] diff;

  always_comb begin
    care   = ~ref_mask & (ref_ide ? {ID_W{1'b1}} : STD_WIN);
    diff   = (frm_id ^ ref_id) & care;
    id_hit = (frm_ide == ref_ide) && (diff == '0);
  end
endmodule

// File: rtl/wkm_data_cmp.sv
module wkm_data_cmp
  import wkm_pkg::*;
(
  input  logic             dme,
  input  logic [DLC_W-1:0] ref_dlc,
  input  logic [PAY_W-1:0] pat,
  input  logic             frm_rtr,
  input  logic [DLC_W-1:0] frm_dlc,
  input  logic [PAY_W-1:0] frm_data,
  output logic             data_ok
);
  logic [MAX_BYTES-1:0] byte_hit;

  for (genvar k = 0; k < MAX_BYTES; k++) begin : g_byte
    logic used;
    assign used        = (int'(frm_dlc) > k);
    assign byte_hit[k] = used && |(frm_data[k*BYTE_W +: BYTE_W] & pat[k*BYTE_W +: BYTE_W]);
  end

  always_comb begin
    if (!dme) data_ok = 1'b1;
    else      data_ok = !frm_rtr && (frm_dlc == ref_dlc) && (byte_hit != '0);
  end
endmodule

// File: rtl/wake_frame_matcher.sv
module wake_frame_matcher
  import wkm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [BYTE_W-1:0] cfg_wdata,
  input  logic              wake_en,
  input  logic              frm_valid,
  input  logic [ID_W-1:0]   frm_id,
  input  logic              frm_ide,
  input  logic              frm_rtr,
  input  logic [DLC_W-1:0]  frm_dlc,
  input  logic [PAY_W-1:0]  frm_data,
  output logic              wake_match
);
  logic     rst_meta_q, rst_sync_n;
  wkm_cfg_t cfg;
  logic     id_hit, data_ok;
  logic     match_d, match_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  wkm_cfg_regs i_regs (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .cfg   (cfg)
  );

  wkm_id_cmp i_id (
    .ref_id   (cfg.id),
    .ref_mask (cfg.mask),
    .ref_ide  (cfg.ide),
    .frm_id   (frm_id),
    .frm_ide  (frm_ide),
    .id_hit   (id_hit)
  );

  wkm_data_cmp i_data (
    .dme      (cfg.dme),
    .ref_dlc  (cfg.dlc),
    .pat      (cfg.pat),
    .frm_rtr  (frm_rtr),
    .frm_dlc  (frm_dlc),
    .frm_data (frm_data),
    .data_ok  (data_ok)
  );

  always_comb begin
    match_d = frm_valid && wake_en && id_hit && data_ok;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) match_q <= 1'b0;
    else             match_q <= match_d;
  end

  assign wake_match = match_q;

  assert_pulse_after_strobe_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wake_match |-> $past(frm_valid));

  assert_pulse_single_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wake_match && !frm_valid) |=> !wake_match);

  assert_wake_gate_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wake_match |-> $past(wake_en));

  assert_ide_agree_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wake_match |-> ($past(frm_ide) == $past(cfg.ide)));

  assert_no_remote_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wake_match && $past(cfg.dme)) |-> !$past(frm_rtr));

  assert_dlc_zero_fails_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wake_match && $past(cfg.dme)) |-> ($past(frm_dlc) != '0));
endmodule

// File: tb/test_wake_frame_matcher.sv
module test_wake_frame_matcher;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [4:0]  cfg_addr;
  logic [7:0]  cfg_wdata;
  logic        wake_en;
  logic        frm_valid;
  logic [28:0] frm_id;
  logic        frm_ide, frm_rtr;
  logic [3:0]  frm_dlc;
  logic [63:0] frm_data;
  logic        wake_match;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [28:0] s_id, s_mask;
  logic        s_ide, s_dme;
  logic [3:0]  s_dlc;
  logic [63:0] s_pat;

  bit    exp_q[$];
  string tag_q[$];
  logic  armed;

  always #(CLK_PERIOD/2) clk = ~clk;

  wake_frame_matcher i_wake_frame_matcher (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .wake_en(wake_en), .frm_valid(frm_valid),
    .frm_id(frm_id), .frm_ide(frm_ide), .frm_rtr(frm_rtr),
    .frm_dlc(frm_dlc), .frm_data(frm_data), .wake_match(wake_match)
  );

  function automatic bit model(logic [28:0] fid, logic fide, logic frtr,
                               logic [3:0] fdlc, logic [63:0] fdata, logic wen);
    bit ok;
    bit hit;
    int nb;
    ok = wen && (fide == s_ide);
    for (int b = 0; b < 29; b++) begin
      if ((s_ide || b >= 18) && !s_mask[b] && (fid[b] != s_id[b])) ok = 0;
    end
    if (s_dme) begin
      hit = 0;
      nb  = (fdlc > 8) ? 8 : int'(fdlc);
      for (int k = 0; k < nb; k++) if ((fdata[8*k +: 8] & s_pat[8*k +: 8]) != 0) hit = 1;
      if (frtr || fdlc != s_dlc || !hit) ok = 0;
    end
    return ok;
  endfunction

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic set_id(input logic [28:0] id, input logic ide);
    wr(0, id[17:10]); wr(1, id[9:2]);
    wr(2, {id[1:0], ide, id[28:24]}); wr(3, {id[23:18], 2'b11});
    s_id = id; s_ide = ide;
  endtask

  task automatic set_mask(input logic [28:0] m);
    wr(4, m[17:10]); wr(5, m[9:2]);
    wr(6, {m[1:0], 1'b1, m[28:24]}); wr(7, {m[23:18], 2'b11});
    s_mask = m;
  endtask

  task automatic set_ctrl(input logic [3:0] dlc, input logic dme);
    wr(8, {3'b111, dme, dlc});
    s_dlc = dlc; s_dme = dme;
  endtask

  task automatic set_pat(input int k, input logic [7:0] v);
    wr(5'(9 + k), v);
    s_pat[8*k +: 8] = v;
  endtask

  task automatic send(input string tag, input logic [28:0] fid, input logic fide,
                      input logic frtr, input logic [3:0] fdlc, input logic [63:0] fdata,
                      input logic wen);
    exp_q.push_back(model(fid, fide, frtr, fdlc, fdata, wen));
    tag_q.push_back(tag);
    @(negedge clk);
    frm_valid = 1; frm_id = fid; frm_ide = fide; frm_rtr = frtr;
    frm_dlc = fdlc; frm_data = fdata; wake_en = wen;
    @(negedge clk);
    frm_valid = 0; wake_en = 1;
  endtask

  task automatic check_low(input string tag);
    checks++;
    if (wake_match !== 1'b0) begin
      fails++;
      $display("FAIL %s: wake_match actual %b expected 0", tag, wake_match);
    end
  endtask

  always @(posedge clk) armed <= frm_valid;

  always @(negedge clk) begin
    if (armed === 1'b1 && exp_q.size() > 0) begin
      bit    e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (wake_match !== e) begin
        fails++;
        $display("FAIL %s: wake_match actual %b expected %b", t, wake_match, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [28:0] ext;
    logic [28:0] sid;
    rst_n = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0; wake_en = 1;
    frm_valid = 0; frm_id = 0; frm_ide = 0; frm_rtr = 0; frm_dlc = 0; frm_data = 0;
    s_id = 0; s_mask = 0; s_ide = 0; s_dme = 0; s_dlc = 0; s_pat = 0;
    repeat (3) @(negedge clk);
    check_low("R1 in reset");
    rst_n = 1;
    repeat (3) @(negedge clk);
    check_low("R1 after reset");

    send("R1 default std id 0", 29'h0, 0, 0, 0, 64'h0, 1);
    send("R1 default std id other", 29'h1 << 18, 0, 0, 0, 64'h0, 1);

    sid = {11'h123, 18'h0};
    set_id(sid, 0);
    send("R3 std exact", sid, 0, 0, 8, 64'h0, 1);
    @(negedge clk);
    check_low("R2 pulse one cycle");
    send("R3 std bit differs", sid ^ (29'h1 << 20), 0, 0, 8, 64'h0, 1);
    set_mask(29'h1 << 20);
    send("R3 masked bit", sid ^ (29'h1 << 20), 0, 0, 8, 64'h0, 1);
    send("R6 std low bits ignored", sid | 29'h3FFFF, 0, 0, 8, 64'h0, 1);
    send("R4 ide mismatch", sid, 1, 0, 8, 64'h0, 1);
    send("R11 wake disabled", sid, 0, 0, 8, 64'h0, 0);
    send("R7 remote allowed", sid, 0, 1, 3, 64'h0, 1);
    send("R2 back to back miss", sid ^ (29'h1 << 28), 0, 0, 8, 64'h0, 1);

    ext = 29'h1ABCDE12;
    set_mask(29'h0);
    set_id(ext, 1);
    send("R5 ext exact", ext, 1, 0, 0, 64'h0, 1);
    send("R5 ext bit0", ext ^ 29'h1, 1, 0, 0, 64'h0, 1);
    send("R5 ext bit10", ext ^ (29'h1 << 10), 1, 0, 0, 64'h0, 1);
    send("R5 ext bit20", ext ^ (29'h1 << 20), 1, 0, 0, 64'h0, 1);
    send("R4 std frame vs ext cfg", ext, 0, 0, 0, 64'h0, 1);
    set_mask(29'h1 << 20);
    send("R5 mask byte3 bit20", ext ^ (29'h1 << 20), 1, 0, 0, 64'h0, 1);
    set_mask(29'h3);
    send("R5 mask byte2 bits1:0", ext ^ 29'h3, 1, 0, 0, 64'h0, 1);

    set_ctrl(4'd4, 1);
    set_pat(2, 8'h10);
    send("R9 shared bit", ext, 1, 0, 4, 64'h0000_0000_0010_0000, 1);
    send("R9 disjoint bits", ext, 1, 0, 4, 64'h0000_0000_00EF_0000, 1);
    send("R9 superset hits", ext, 1, 0, 4, 64'h0000_0000_00FF_0000, 1);
    send("R8 dlc mismatch", ext, 1, 0, 5, 64'h0000_0000_0010_0000, 1);
    send("R8 remote refused", ext, 1, 1, 4, 64'h0000_0000_0010_0000, 1);
    set_ctrl(4'd2, 1);
    send("R10 byte beyond dlc", ext, 1, 0, 2, 64'h0000_0000_0010_0000, 1);
    set_ctrl(4'd0, 1);
    send("R10 dlc zero", ext, 1, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 1);
    set_ctrl(4'd9, 1);
    set_pat(7, 8'h81);
    send("R10 dlc 9 uses byte7", ext, 1, 0, 9, 64'h0100_0000_0000_0000, 1);
    set_pat(0, 8'h02);
    send("R12 pattern byte0", ext, 1, 0, 9, 64'h0000_0000_0000_0002, 1);
    wr(5'd20, 8'hFF);
    send("R12 write above range ignored", ext, 1, 0, 9, 64'h0000_0000_0000_0001, 1);
    set_ctrl(4'd9, 0);
    send("R7 dme off ignores dlc data", ext, 1, 1, 0, 64'h0, 1);

    repeat (3) @(negedge clk);
    check_low("R2 idle after frames");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule